// File: doc/BRIEF.md
# Broadcast Constant Cache

This block is a small read-only cache that sits between a group of SIMD lanes and a larger region of constant data in device memory. A batch of lane reads is handed over in one cycle: a request bit and a byte address for every lane. The cache looks up each distinct word address once and returns the word to every active lane that asked for it. When all lanes ask for the same word, one lookup feeds them all in the same cycle.

Lanes that ask for different words are served one distinct word per cycle. The lowest-numbered lane still waiting picks the word for that cycle. A hit is served from the on-chip arrays alone. A miss sends exactly one word read to the backing memory over a valid/ready request channel and waits for the response. The response is handed to the waiting lanes and written into the arrays in the same cycle. The block raises `busy` while a batch is in progress. An invalidate input clears every entry in one cycle. Lanes never write, so there is no write path and no coherence logic.

The arrays are direct-mapped with one data word per line. The byte address is split into a word offset, a line index and a tag, and the default sizes hold an 8 KB working set out of a 64 KB constant space.

Top module: `cc_const_cache`

## Requirements
- R1: While reset is asserted, and right after it, `busy`, `done`, `mem_req_valid` and every `lane_rvalid` bit are low and every `lane_data` word is zero.
- R2: A batch is taken only when `batch_valid` is high, `busy` is low and at least one `lane_req` bit is set. `busy` is high from the next cycle. A batch offered while `busy` is high, or with no request bit set, is ignored and causes no output activity.
- R3: A distinct word found valid with a matching tag is served one cycle after its lookup with no backing-memory request. A batch whose k distinct words all hit raises `done` exactly k cycles after the accepting edge. Served lanes get the word stored at that address.
- R4: A missing word causes exactly one backing request, for the word address (byte address shifted right by two). The response data is delivered to the waiting lanes in the cycle after `mem_rsp_valid`.
- R5: Lanes whose addresses differ only in the two low byte-offset bits share one word. All such active lanes are served by a single lookup, with their `lane_rvalid` bits high in the same cycle.
- R6: Distinct words are served in ascending order of the lowest active lane that asked for each. Each active lane is served exactly once per batch.
- R7: A lane whose request bit was clear in the accepted batch never sees `lane_rvalid`, and its `lane_data` keeps its previous value.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` stays unchanged.
- R9: At most one fill is outstanding: after a request handshake, no new request is raised until the response arrives.
- R10: A cycle with `inval_all` high leaves every entry invalid, so the next access to any word misses. If the invalidate coincides with a fill response, the invalidate wins and that word is not retained.
- R11: The arrays are direct-mapped on word-address bits [IDXW-1:0]. A fill for a word with the same index but a different tag replaces the resident word, and the replaced word misses when it is next accessed.
- R12: `done` pulses high for one cycle together with the final `lane_rvalid` pulse of a batch, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| batch_valid | input | 1 | Offers a batch of lane reads |
| lane_req | input | LANES | Per-lane active bit of the offered batch |
| lane_addr | input | LANES*AW | Per-lane byte address, lane 0 in the low bits |
| inval_all | input | 1 | Clears every entry at the next edge |
| busy | output | 1 | High while a batch is being served |
| done | output | 1 | One-cycle pulse with the last lane result of a batch |
| lane_rvalid | output | LANES | Per-lane one-cycle result strobe |
| lane_data | output | LANES*DW | Per-lane result word, held between strobes |
| mem_req_valid | output | 1 | Backing fill request valid |
| mem_req_ready | input | 1 | Backing memory takes the request |
| mem_req_addr | output | AW-2 | Word address of the fill |
| mem_rsp_valid | input | 1 | Fill response valid |
| mem_rsp_data | input | DW | Fill response word |

## Verification
The bench builds the block with eight lanes and 16-bit addresses, but with a 4-bit index, so only 16 lines are present. This makes index conflicts, evictions and refills easy to reach with a handful of addresses, including conflicts inside a single batch. The backing model can hold off `mem_req_ready` and delay its response by chosen cycle counts. It can also raise the invalidate in the same cycle as a response. Batch latency is timed exactly for batches where every word hits.

// File: rtl/cc_pkg.sv
package cc_pkg;

  // Phase of batch service in the top controller
  typedef enum logic [1:0] {
    CC_IDLE,
    CC_LOOK,
    CC_FILL
  } cc_phase_e;

  // Phase of the backing-memory fill port
  typedef enum logic [1:0] {
    FP_IDLE,
    FP_REQ,
    FP_WAIT
  } fp_phase_e;

endpackage

// File: rtl/cc_lane_picker.sv
module cc_lane_picker #(
  parameter int LANES = 8,
  parameter int WAW   = 14
) (
  input  logic [LANES-1:0]     pend,
  input  logic [LANES*WAW-1:0] waddr,
  output logic                 any_pend,
  output logic [WAW-1:0]       sel_waddr,
  output logic [LANES-1:0]     match
);
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1;

  // lowest set position of a mask (0 when empty)
  function automatic logic [SELW-1:0] first_lane(input logic [LANES-1:0] m);
    logic [SELW-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = SELW'(i);
    end
    return r;
  endfunction

  logic [SELW-1:0] sel;

  assign sel       = first_lane(pend);
  assign sel_waddr = waddr[int'(sel)*WAW +: WAW];
  assign any_pend  = |pend;

  // every waiting lane asking for the selected word joins this lookup
  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign match[g] = pend[g] && (waddr[g*WAW +: WAW] == sel_waddr);
  end

endmodule

// File: rtl/cc_store.sv
module cc_store #(
  parameter int IDXW = 11,
  parameter int TAGW = 3,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [TAGW-1:0] lk_tag,
  output logic            entry_hit,
  output logic [DW-1:0]   lk_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [DW-1:0]   wr_data,
  input  logic            inval_all
);
  localparam int DEPTH = 1 << IDXW;

  logic [DEPTH-1:0] vld;
  logic [TAGW-1:0]  tag_mem [DEPTH];
  logic [DW-1:0]    dat_mem [DEPTH];

  // invalidate takes priority over a fill landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (inval_all) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= wr_data;
    end
  end

  assign entry_hit = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_data   = dat_mem[lk_idx];

endmodule

// File: rtl/cc_fill_port.sv
module cc_fill_port
  import cc_pkg::*;
#(
  parameter int WAW = 14,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [WAW-1:0] start_waddr,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [WAW-1:0] mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           fill_done,
  output logic [DW-1:0]  fill_data
);
  fp_phase_e      ph;
  logic [WAW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= FP_IDLE;
      addr_q <= '0;
    end else begin
      case (ph)
        FP_IDLE: if (start) begin
          addr_q <= start_waddr;
          ph     <= FP_REQ;
        end
        FP_REQ:  if (mem_req_ready) ph <= FP_WAIT;
        FP_WAIT: if (mem_rsp_valid) ph <= FP_IDLE;
        default: ph <= FP_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (ph == FP_REQ);
  assign mem_req_addr  = addr_q;
  assign fill_done     = (ph == FP_WAIT) && mem_rsp_valid;
  assign fill_data     = mem_rsp_data;

endmodule

// File: rtl/cc_lane_out.sv
module cc_lane_out #(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    serve_mask,
  input  logic [DW-1:0]       serve_data,
  output logic [LANES-1:0]    lane_rvalid,
  output logic [LANES*DW-1:0] lane_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_rvalid[g]          <= 1'b0;
        lane_data[g*DW +: DW]   <= '0;
      end else begin
        lane_rvalid[g] <= serve_mask[g];
        if (serve_mask[g]) lane_data[g*DW +: DW] <= serve_data;
      end
    end
  end

endmodule

// File: rtl/cc_const_cache.sv
module cc_const_cache
  import cc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IDXW  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                batch_valid,
  input  logic [LANES-1:0]    lane_req,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic                inval_all,
  output logic                busy,
  output logic                done,
  output logic [LANES-1:0]    lane_rvalid,
  output logic [LANES*DW-1:0] lane_data,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [AW-3:0]       mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data
);
  localparam int BYTE_LSB = $clog2(DW / 8);
  localparam int WAW      = AW - BYTE_LSB;
  localparam int TAGW     = WAW - IDXW;

  function automatic logic [WAW-1:0] word_of(input logic [AW-1:0] a);
    return a[AW-1:BYTE_LSB];
  endfunction

  function automatic logic [IDXW-1:0] idx_of(input logic [WAW-1:0] w);
    return w[IDXW-1:0];
  endfunction

  function automatic logic [TAGW-1:0] tag_of(input logic [WAW-1:0] w);
    return w[WAW-1:IDXW];
  endfunction

  cc_phase_e               phase;
  logic [LANES-1:0]        pend_q;
  logic [LANES*WAW-1:0]    waddr_q;
  logic [LANES*WAW-1:0]    cap_waddr;
  logic [LANES*BYTE_LSB-1:0] addr_lsb_unused;
  logic                    done_q;

  // named internal events
  logic                    accept_w;
  logic                    lookup_hit_w;
  logic                    lookup_miss_w;
  logic                    serve_w;
  logic                    batch_last_w;

  logic                    any_pend;
  logic [WAW-1:0]          sel_waddr;
  logic [LANES-1:0]        match;
  logic                    entry_hit;
  logic [DW-1:0]           lk_data;
  logic                    fill_done;
  logic [DW-1:0]           fill_data;
  logic [LANES-1:0]        serve_mask;
  logic [DW-1:0]           serve_data;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    assign cap_waddr[g*WAW +: WAW] = word_of(lane_addr[g*AW +: AW]);
    assign addr_lsb_unused[g*BYTE_LSB +: BYTE_LSB] = lane_addr[g*AW +: BYTE_LSB];
  end

  cc_lane_picker #(.LANES(LANES), .WAW(WAW)) picker_i (
    .pend      (pend_q),
    .waddr     (waddr_q),
    .any_pend  (any_pend),
    .sel_waddr (sel_waddr),
    .match     (match)
  );

  cc_store #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (idx_of(sel_waddr)),
    .lk_tag    (tag_of(sel_waddr)),
    .entry_hit (entry_hit),
    .lk_data   (lk_data),
    .wr_en     ((phase == CC_FILL) && fill_done),
    .wr_idx    (idx_of(sel_waddr)),
    .wr_tag    (tag_of(sel_waddr)),
    .wr_data   (fill_data),
    .inval_all (inval_all)
  );

  cc_fill_port #(.WAW(WAW), .DW(DW)) fill_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (lookup_miss_w),
    .start_waddr   (sel_waddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_done     (fill_done),
    .fill_data     (fill_data)
  );

  assign accept_w      = (phase == CC_IDLE) && batch_valid && (|lane_req);
  assign lookup_hit_w  = (phase == CC_LOOK) && any_pend && entry_hit;
  assign lookup_miss_w = (phase == CC_LOOK) && any_pend && !entry_hit;
  assign serve_w       = lookup_hit_w || ((phase == CC_FILL) && fill_done);
  assign batch_last_w  = serve_w && ((pend_q & ~match) == '0);
  assign serve_mask    = serve_w ? match : '0;
  assign serve_data    = (phase == CC_FILL) ? fill_data : lk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= CC_IDLE;
      pend_q  <= '0;
      waddr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= batch_last_w;
      case (phase)
        CC_IDLE: if (accept_w) begin
          phase   <= CC_LOOK;
          pend_q  <= lane_req;
          waddr_q <= cap_waddr;
        end
        CC_LOOK: begin
          if (lookup_hit_w) begin
            pend_q <= pend_q & ~match;
            if (batch_last_w) phase <= CC_IDLE;
          end else if (lookup_miss_w) begin
            phase <= CC_FILL;
          end
        end
        CC_FILL: if (fill_done) begin
          pend_q <= pend_q & ~match;
          phase  <= batch_last_w ? CC_IDLE : CC_LOOK;
        end
        default: phase <= CC_IDLE;
      endcase
    end
  end

  cc_lane_out #(.LANES(LANES), .DW(DW)) out_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .serve_mask  (serve_mask),
    .serve_data  (serve_data),
    .lane_rvalid (lane_rvalid),
    .lane_data   (lane_data)
  );

  assign busy = (phase != CC_IDLE);
  assign done = done_q;

endmodule

// File: rtl/cc_const_cache_chk.sv
module cc_const_cache_chk #(
  parameter int LANES = 8,
  parameter int WAW   = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             batch_valid,
  input logic [LANES-1:0] lane_req,
  input logic             busy,
  input logic             done,
  input logic [LANES-1:0] lane_rvalid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [WAW-1:0]   mem_req_addr,
  input logic             mem_rsp_valid
);
  logic             take_w;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] served_q;
  logic             outst_q;

  assign take_w = !busy && batch_valid && (|lane_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      served_q <= '0;
      outst_q  <= 1'b0;
    end else begin
      if (take_w) begin
        mask_q   <= lane_req;
        served_q <= '0;
      end else begin
        served_q <= served_q | lane_rvalid;
      end
      if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
      else if (mem_rsp_valid)             outst_q <= 1'b0;
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> busy);

  // R7
  idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_rvalid & ~mask_q) == '0);

  // R6
  single_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_rvalid & served_q) == '0);

  // R12
  done_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((|lane_rvalid) && !busy));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_valid);

  // R4
  fill_serves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && mem_rsp_valid) |=> (|lane_rvalid));

endmodule

bind cc_const_cache cc_const_cache_chk #(.LANES(LANES), .WAW(WAW)) chk_i (.*);

// File: tb/cc_const_cache_tb_top.sv
`timescale 1ns/1ps
module cc_const_cache_tb_top;
  localparam int LANES = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int IDXW  = 4;
  localparam int WAW   = AW - 2;
  localparam int DEPTH = 1 << IDXW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                batch_valid = 1'b0;
  logic [LANES-1:0]    lane_req = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic                inval_main = 1'b0;
  logic                inval_rsp = 1'b0;
  logic                inval_all;
  logic                busy, done;
  logic [LANES-1:0]    lane_rvalid;
  logic [LANES*DW-1:0] lane_data;
  logic                mem_req_valid;
  logic                mem_req_ready = 1'b0;
  logic [WAW-1:0]      mem_req_addr;
  logic                mem_rsp_valid = 1'b0;
  logic [DW-1:0]       mem_rsp_data = '0;

  assign inval_all = inval_main | inval_rsp;

  always #10 clk = ~clk;

  cc_const_cache #(.LANES(LANES), .AW(AW), .DW(DW), .IDXW(IDXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .batch_valid(batch_valid), .lane_req(lane_req),
    .lane_addr(lane_addr), .inval_all(inval_all), .busy(busy), .done(done),
    .lane_rvalid(lane_rvalid), .lane_data(lane_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk_eq(input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // backing constant contents, a fixed function of the word address
  function automatic logic [31:0] mem_val(input int w);
    logic [31:0] x;
    x = 32'(w + 1) * 32'h9E3779B1;
    return x ^ 32'h0F0F_0000;
  endfunction

  // reference model state
  int          mtag [DEPTH];
  bit          mvld [DEPTH];
  logic [7:0]  q_mask [$];
  int          q_w [$];
  bit          q_last [$];
  int          q_miss [$];
  logic [31:0] shadow [LANES];
  logic [15:0] baddr [LANES];
  int          stall_cyc = 0;
  int          rsp_lat = 0;
  bit          inval_on_rsp = 0;
  int          fills = 0;

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) mvld[i] = 0;
  endtask

  initial begin
    model_clear();
    for (int l = 0; l < LANES; l++) begin
      shadow[l] = '0;
      baddr[l]  = '0;
    end
  end

  // output monitor: compares the design with the model every cycle
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (lane_rvalid != '0) begin
        if (q_mask.size() == 0) begin
          chk_eq("R2", "rvalid with no batch expected", 64'(lane_rvalid), 64'h0);
        end else begin
          logic [7:0] m;
          int w;
          bit lst;
          m   = q_mask.pop_front();
          w   = q_w.pop_front();
          lst = q_last.pop_front();
          chk_eq("R6", "lanes served this cycle", 64'(lane_rvalid), 64'(m));
          chk_eq("R12", "done on last result", 64'(done), 64'(lst));
          for (int l = 0; l < LANES; l++) begin
            if (m[l]) begin
              chk_eq("R3", "lane data", 64'(lane_data[l*DW +: DW]), 64'(mem_val(w)));
              shadow[l] = mem_val(w);
            end
          end
        end
      end else if (done) begin
        chk_eq("R12", "done without results", 64'h1, 64'h0);
      end
      for (int l = 0; l < LANES; l++) begin
        if (!lane_rvalid[l])
          chk_eq("R7", "lane data held", 64'(lane_data[l*DW +: DW]), 64'(shadow[l]));
      end
    end
  end

  // backing memory responder
  initial begin
    bit pend_rsp;
    int lat_cnt;
    int wcnt;
    int paddr;
    pend_rsp = 0;
    lat_cnt  = 0;
    wcnt     = 0;
    paddr    = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      inval_rsp     = 1'b0;
      mem_req_ready = 1'b0;
      if (pend_rsp) begin
        if (mem_req_valid) chk_eq("R9", "request while fill outstanding", 64'h1, 64'h0);
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_val(paddr);
          pend_rsp      = 0;
          if (inval_on_rsp) begin
            inval_rsp    = 1'b1;
            inval_on_rsp = 0;
          end
        end else begin
          lat_cnt--;
        end
      end else if (mem_req_valid) begin
        if (wcnt >= stall_cyc) begin
          mem_req_ready = 1'b1;
          wcnt     = 0;
          pend_rsp = 1;
          lat_cnt  = rsp_lat;
          paddr    = int'(mem_req_addr);
          fills++;
          if (q_miss.size() == 0)
            chk_eq("R4", "unexpected fill request", 64'(mem_req_addr), 64'h0);
          else
            chk_eq("R4", "fill word address", 64'(mem_req_addr), 64'(q_miss.pop_front()));
        end else begin
          wcnt++;
        end
      end
    end
  end

  // offer one batch, predict its service, and wait for completion
  task automatic run_batch(input logic [7:0] req, input bit poke, output int cycles);
    logic [7:0] left;
    left = req;
    for (int l = 0; l < LANES; l++) begin
      if (left[l]) begin
        int w, i, t;
        logic [7:0] m;
        w = int'(baddr[l][15:2]);
        m = '0;
        for (int j = l; j < LANES; j++)
          if (left[j] && int'(baddr[j][15:2]) == w) m[j] = 1'b1;
        left = left & ~m;
        i = w % DEPTH;
        t = w / DEPTH;
        if (!(mvld[i] && mtag[i] == t)) begin
          q_miss.push_back(w);
          mvld[i] = 1;
          mtag[i] = t;
        end
        q_mask.push_back(m);
        q_w.push_back(w);
        q_last.push_back(left == '0);
      end
    end
    @(negedge clk);
    batch_valid = 1'b1;
    lane_req    = req;
    for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = baddr[l];
    @(negedge clk);
    batch_valid = 1'b0;
    if (poke) begin
      batch_valid = 1'b1;
      lane_req    = 8'hFF;
      lane_addr   = '1;
    end
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      if (poke && cycles == 0) batch_valid = 1'b0;
      cycles++;
    end
    @(negedge clk);
    chk_eq("R12", "every expected result delivered", 64'(q_mask.size()), 64'h0);
    chk_eq("R4", "every expected fill issued", 64'(q_miss.size()), 64'h0);
    chk_eq("R12", "idle after batch", 64'(busy), 64'h0);
  endtask

  task automatic invalidate();
    @(negedge clk);
    inval_main = 1'b1;
    @(negedge clk);
    inval_main = 1'b0;
    model_clear();
  endtask

  function automatic int lcg(input int s);
    return s * 1103515245 + 12345;
  endfunction

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc, f0, seed;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "busy in reset", 64'(busy), 64'h0);
    chk_eq("R1", "done in reset", 64'(done), 64'h0);
    chk_eq("R1", "rvalid in reset", 64'(lane_rvalid), 64'h0);
    chk_eq("R1", "fill request in reset", 64'(mem_req_valid), 64'h0);
    chk_eq("R1", "lane data in reset", 64'(|lane_data), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "busy after reset", 64'(busy), 64'h0);

    // single lane miss then hit (R4, R3)
    baddr[3] = 16'h0124;
    f0 = fills;
    run_batch(8'b0000_1000, 0, cyc);
    chk_eq("R4", "one fill for a miss", 64'(fills - f0), 64'h1);
    f0 = fills;
    run_batch(8'b0000_1000, 0, cyc);
    chk_eq("R3", "hit latency", 64'(cyc), 64'h1);
    chk_eq("R3", "no fill on hit", 64'(fills - f0), 64'h0);

    // broadcast, offsets in the low bits ignored (R5)
    for (int l = 0; l < LANES; l++) baddr[l] = 16'h0200 + 16'(l % 4);
    f0 = fills;
    run_batch(8'hFF, 0, cyc);
    chk_eq("R5", "one fill for shared word", 64'(fills - f0), 64'h1);
    run_batch(8'hFF, 0, cyc);
    chk_eq("R5", "broadcast hit in one cycle", 64'(cyc), 64'h1);

    // distinct words with throttled backing memory (R6, R8)
    stall_cyc = 2;
    rsp_lat   = 3;
    baddr[0] = 16'h0304; baddr[1] = 16'h0010; baddr[2] = 16'h0304;
    baddr[3] = 16'h0408; baddr[4] = 16'h0010; baddr[5] = 16'h0020;
    baddr[6] = 16'h0408; baddr[7] = 16'h050C;
    f0 = fills;
    run_batch(8'hFF, 0, cyc);
    chk_eq("R8", "fills under throttling", 64'(fills - f0), 64'h5);
    stall_cyc = 0;
    rsp_lat   = 0;
    run_batch(8'hFF, 0, cyc);
    chk_eq("R6", "five distinct hits take five cycles", 64'(cyc), 64'h5);

    // inactive lanes keep data (R7)
    baddr[1] = 16'h0030; baddr[6] = 16'h0034;
    run_batch(8'b0100_0010, 0, cyc);
    chk_eq("R7", "lane 0 untouched", 64'(lane_data[0 +: DW]), 64'(mem_val(16'h0304 >> 2)));
    chk_eq("R7", "lane 7 untouched", 64'(lane_data[7*DW +: DW]), 64'(mem_val(16'h050C >> 2)));

    // direct-mapped conflict (R11)
    baddr[0] = 16'h0040; baddr[1] = 16'h0080;
    f0 = fills;
    run_batch(8'b0000_0011, 0, cyc);
    chk_eq("R11", "two fills for same index", 64'(fills - f0), 64'h2);
    f0 = fills;
    run_batch(8'b0000_0001, 0, cyc);
    chk_eq("R11", "evicted word refilled", 64'(fills - f0), 64'h1);

    // invalidate between batches (R10)
    baddr[3] = 16'h0124;
    run_batch(8'b0000_1000, 0, cyc);
    chk_eq("R10", "resident before invalidate", 64'(cyc), 64'h1);
    invalidate();
    f0 = fills;
    run_batch(8'b0000_1000, 0, cyc);
    chk_eq("R10", "miss after invalidate", 64'(fills - f0), 64'h1);

    // invalidate on the fill response cycle wins (R10)
    baddr[2] = 16'h0600;
    inval_on_rsp = 1;
    run_batch(8'b0000_0100, 0, cyc);
    model_clear();
    f0 = fills;
    run_batch(8'b0000_0100, 0, cyc);
    chk_eq("R10", "fill dropped by coincident invalidate", 64'(fills - f0), 64'h1);

    // offer while busy is ignored (R2)
    baddr[5] = 16'h0700;
    rsp_lat  = 2;
    run_batch(8'b0010_0000, 1, cyc);
    rsp_lat  = 0;

    // offer with no lane active is ignored (R2)
    @(negedge clk);
    batch_valid = 1'b1;
    lane_req    = '0;
    @(negedge clk);
    batch_valid = 1'b0;
    chk_eq("R2", "empty offer not taken", 64'(busy), 64'h0);

    // pseudo-random sweep over a small word range
    seed = 32'h1234;
    for (int b = 0; b < 60; b++) begin
      logic [7:0] rq;
      seed = lcg(seed);
      rq = 8'(seed >>> 8);
      if (rq == 0) rq = 8'h01;
      for (int l = 0; l < LANES; l++) begin
        seed = lcg(seed);
        baddr[l] = 16'((seed >>> 10) & 32'h00FF);
        if (b % 7 == 0) baddr[l] = 16'h0088;
      end
      stall_cyc = b % 3;
      rsp_lat   = b % 4;
      run_batch(rq, 0, cyc);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule